// File: doc/BRIEF.md
# Weighted Multi-Channel Scan Pattern Generator

This block supplies one pseudo-random scan-in bit per scan channel on every cycle of a self-test run. A Fibonacci shift register holds the pattern state. A phase-shifting network of XOR gates then derives several streams per channel, so that neighbouring channels do not see the same sequence merely displaced by one position. A weighting stage per channel combines those streams to bias how often a one appears. Each channel's bit is then gated by that channel's enable and registered before it leaves the block.

The seed, the per-channel weight codes and the per-channel enables all arrive serially through a configuration shift ring. Shifting does not disturb the running pattern. The new setup takes effect together on the cycle after the load strobe falls, which starts a new test block from the new seed. Between loads, the state register moves one step for each advance strobe.

Top module: `scanpat_gen`

## Requirements
- R1: During and directly after synchronous active-high reset, every channel output is 0, every channel enable is 0, every weight code is 00, and the state register holds the parameter RESET_SEED.
- R2: While `cfg_shift` is 1, each clock shifts `cfg_bit` into bit 0 of a ring of STATE_W+3*CHANNELS bits, and the older bits move one place up, so the bit sent first ends in the top position. In the finished ring, bits [STATE_W-1:0] are the seed, bits [STATE_W+2c+1:STATE_W+2c] are channel c's weight code, and bit STATE_W+2*CHANNELS+c is channel c's enable. On the first clock with `cfg_shift` at 0 after a clock with it at 1, the seed is loaded into the state register and the weights and enables become active.
- R3: A seed of all zeros is replaced at load time by the parameter ZERO_SUB (nonzero). The state register is never zero.
- R4: The state register shifts left by one, taking as its new bit 0 the XOR of the state bits selected by TAP_MASK. It does so only on a clock where `step` is 1, `cfg_shift` is 0 and no load takes effect. Otherwise it holds its value.
- R5: Channel c uses three streams d0, d1 and d2. Stream dj is the XOR of state bits a=3c+j and (a+SKEW) mod STATE_W.
- R6: Weight code 00 outputs d0 (a one half of the time). Code 01 outputs d0 AND d1 (one quarter). Code 10 outputs d0 OR d1 (three quarters). Code 11 outputs d0 AND d1 AND d2 (one eighth).
- R7: A channel whose enable is 0 outputs 0 whatever the state and weight code.
- R8: The outputs are registered. They reflect the state, weights and enables that held on the previous clock.
- R9: Shifting the configuration ring does not change the active weights, the active enables or the channel outputs until the load takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Advance the pattern state by one position |
| cfg_shift | input | 1 | Shift enable for the configuration ring; its falling edge applies the ring |
| cfg_bit | input | 1 | Serial configuration data |
| chan_out | output | CHANNELS | Registered scan-in bit per channel |

## Verification
The assertions take for granted that `cfg_shift` stays at 1 for at least one whole clock before it falls, and that `step` may arrive at any time, including during a load. They also assume SKEW and the channel count keep every tap pair distinct (3*CHANNELS no larger than STATE_W). The stimulus drives every input at the falling clock edge and holds `cfg_shift` for exactly the ring length in each load. It asserts `step` during shifting only in the case that checks it is ignored, and uses the default parameters, which meet the tap condition.

// File: rtl/scanpat_pkg.sv
package scanpat_pkg;
  typedef enum logic [1:0] {
    WT_HALF    = 2'b00,
    WT_QUARTER = 2'b01,
    WT_3QUART  = 2'b10,
    WT_EIGHTH  = 2'b11
  } wt_code_e;

  // first tap of stream j for channel c
  function automatic int tap_lo(input int c, input int j);
    return 3 * c + j;
  endfunction

  // partner tap of the same stream
  function automatic int tap_hi(input int c, input int j, input int skew, input int width);
    return (3 * c + j + skew) % width;
  endfunction
endpackage

// File: rtl/scanpat_cfg_ring.sv
module scanpat_cfg_ring #(
  parameter int STATE_W  = 32,
  parameter int CHANNELS = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_shift,
  input  logic                    cfg_bit,
  output logic                    apply,
  output logic [STATE_W-1:0]      seed_img,
  output logic [2*CHANNELS-1:0]   wt_act,
  output logic [CHANNELS-1:0]     en_act
);
  localparam int WT_BASE = STATE_W;
  localparam int EN_BASE = STATE_W + 2 * CHANNELS;
  localparam int RING_W  = EN_BASE + CHANNELS;

  logic [RING_W-1:0] ring;
  logic              shift_q;

  assign apply    = shift_q && !cfg_shift;
  assign seed_img = ring[STATE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ring    <= '0;
      shift_q <= 1'b0;
    end else begin
      shift_q <= cfg_shift;
      if (cfg_shift) ring <= {ring[RING_W-2:0], cfg_bit};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wt_act <= '0;
      en_act <= '0;
    end else if (apply) begin
      wt_act <= ring[WT_BASE +: 2*CHANNELS];
      en_act <= ring[EN_BASE +: CHANNELS];
    end
  end
endmodule

// File: rtl/scanpat_lfsr.sv
module scanpat_lfsr #(
  parameter int               STATE_W    = 32,
  parameter logic [STATE_W-1:0] TAP_MASK   = 32'h8020_0003,
  parameter logic [STATE_W-1:0] RESET_SEED = 32'hACE1_2468,
  parameter logic [STATE_W-1:0] ZERO_SUB   = 32'h0000_0001
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic               cfg_shift,
  input  logic               apply,
  input  logic [STATE_W-1:0] seed_in,
  output logic [STATE_W-1:0] state
);
  logic fb;
  assign fb = ^(state & TAP_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RESET_SEED;
    end else if (apply) begin
      state <= (seed_in == '0) ? ZERO_SUB : seed_in;
    end else if (step && !cfg_shift) begin
      state <= {state[STATE_W-2:0], fb};
    end
  end
endmodule

// File: rtl/scanpat_lane.sv
module scanpat_lane
  import scanpat_pkg::*;
#(
  parameter int STATE_W = 32,
  parameter int CH_IDX  = 0,
  parameter int SKEW    = 13
) (
  input  logic [STATE_W-1:0] state,
  input  logic [1:0]         wcode,
  input  logic               enable,
  output logic               bit_out
);
  logic [2:0] strm;
  logic       weighted;

  for (genvar j = 0; j < 3; j++) begin : g_strm
    localparam int LO = tap_lo(CH_IDX, j);
    localparam int HI = tap_hi(CH_IDX, j, SKEW, STATE_W);
    assign strm[j] = state[LO] ^ state[HI];
  end

  always_comb begin
    case (wt_code_e'(wcode))
      WT_HALF:    weighted = strm[0];
      WT_QUARTER: weighted = strm[0] & strm[1];
      WT_3QUART:  weighted = strm[0] | strm[1];
      default:    weighted = &strm;
    endcase
  end

  assign bit_out = enable & weighted;
endmodule

// File: rtl/scanpat_gen.sv
module scanpat_gen #(
  parameter int                 CHANNELS   = 8,
  parameter int                 STATE_W    = 32,
  parameter int                 SKEW       = 13,
  parameter logic [STATE_W-1:0] TAP_MASK   = 32'h8020_0003,
  parameter logic [STATE_W-1:0] RESET_SEED = 32'hACE1_2468,
  parameter logic [STATE_W-1:0] ZERO_SUB   = 32'h0000_0001
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step,
  input  logic                cfg_shift,
  input  logic                cfg_bit,
  output logic [CHANNELS-1:0] chan_out
);
  logic                  apply;
  logic [STATE_W-1:0]    seed_img;
  logic [2*CHANNELS-1:0] wt_act;
  logic [CHANNELS-1:0]   en_act;
  logic [STATE_W-1:0]    lfsr_state;
  logic [CHANNELS-1:0]   lane_bits;

  scanpat_cfg_ring #(.STATE_W(STATE_W), .CHANNELS(CHANNELS)) u_ring (
    .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_bit(cfg_bit),
    .apply(apply), .seed_img(seed_img), .wt_act(wt_act), .en_act(en_act)
  );

  scanpat_lfsr #(
    .STATE_W(STATE_W), .TAP_MASK(TAP_MASK),
    .RESET_SEED(RESET_SEED), .ZERO_SUB(ZERO_SUB)
  ) u_lfsr (
    .clk(clk), .rst(rst), .step(step), .cfg_shift(cfg_shift),
    .apply(apply), .seed_in(seed_img), .state(lfsr_state)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_lane
    scanpat_lane #(.STATE_W(STATE_W), .CH_IDX(c), .SKEW(SKEW)) u_lane (
      .state(lfsr_state), .wcode(wt_act[2*c +: 2]),
      .enable(en_act[c]), .bit_out(lane_bits[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) chan_out <= '0;
    else     chan_out <= lane_bits;
  end
endmodule

// File: rtl/scanpat_gen_chk.sv
module scanpat_gen_chk #(
  parameter int                 CHANNELS = 8,
  parameter int                 STATE_W  = 32,
  parameter logic [STATE_W-1:0] ZERO_SUB = 32'h0000_0001
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  step,
  input logic                  cfg_shift,
  input logic                  apply,
  input logic [STATE_W-1:0]    seed_img,
  input logic [STATE_W-1:0]    lfsr_state,
  input logic [2*CHANNELS-1:0] wt_act,
  input logic [CHANNELS-1:0]   en_act,
  input logic [CHANNELS-1:0]   chan_out
);
  // R7
  dis_chan_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_out & ~$past(en_act)) == '0);

  // R3
  state_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    lfsr_state != '0);

  // R3
  zero_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (apply && seed_img == '0) |=> lfsr_state == ZERO_SUB);

  // R4
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    ((!step || cfg_shift) && !apply) |=> $stable(lfsr_state));

  // R4
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !cfg_shift && !apply) |=> lfsr_state != $past(lfsr_state));

  // R9
  cfg_stable_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_shift |=> ($stable(wt_act) && $stable(en_act)));
endmodule

bind scanpat_gen scanpat_gen_chk #(
  .CHANNELS(CHANNELS), .STATE_W(STATE_W), .ZERO_SUB(ZERO_SUB)
) u_chk (
  .clk(clk), .rst(rst), .step(step), .cfg_shift(cfg_shift),
  .apply(apply), .seed_img(seed_img), .lfsr_state(lfsr_state),
  .wt_act(wt_act), .en_act(en_act), .chan_out(chan_out)
);

// File: tb/scanpat_gen_test.sv
module scanpat_gen_test;
  localparam int N    = 8;
  localparam int W    = 32;
  localparam int SKEW = 13;
  localparam logic [W-1:0] TAPS  = 32'h8020_0003;
  localparam logic [W-1:0] RSEED = 32'hACE1_2468;
  localparam logic [W-1:0] ZSUB  = 32'h0000_0001;
  localparam int RING = W + 3 * N;

  logic clk = 0, rst = 1, step = 0, cfg_shift = 0, cfg_bit = 0;
  logic [N-1:0] chan_out;
  int checks = 0, fails = 0;

  logic [W-1:0]   m_state = RSEED;
  logic [2*N-1:0] m_wt = '0;
  logic [N-1:0]   m_en = '0;
  logic [N-1:0]   expq[$];
  string          tagq[$];
  logic p1 = 0, p2 = 0;

  always #10 clk = ~clk;

  scanpat_gen #(.CHANNELS(N), .STATE_W(W), .SKEW(SKEW), .TAP_MASK(TAPS),
                .RESET_SEED(RSEED), .ZERO_SUB(ZSUB)) uut (
    .clk(clk), .rst(rst), .step(step), .cfg_shift(cfg_shift),
    .cfg_bit(cfg_bit), .chan_out(chan_out)
  );

  function automatic logic [N-1:0] model_out(logic [W-1:0] s, logic [2*N-1:0] wt, logic [N-1:0] en);
    logic [N-1:0] r;
    for (int c = 0; c < N; c++) begin
      logic [2:0] d;
      for (int j = 0; j < 3; j++) d[j] = s[3*c+j] ^ s[(3*c+j+SKEW) % W];
      case (wt[2*c +: 2])
        2'b00: r[c] = d[0];
        2'b01: r[c] = d[0] & d[1];
        2'b10: r[c] = d[0] | d[1];
        default: r[c] = d[0] & d[1] & d[2];
      endcase
      r[c] = r[c] & en[c];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: chan_out=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor: compare two edges after each step
  always @(posedge clk) begin p1 <= step; p2 <= p1; end
  always @(negedge clk) begin
    if (p2 && expq.size() > 0) check(tagq.pop_front(), chan_out, expq.pop_front());
  end

  task automatic do_step(string tag);
    @(negedge clk); step = 1;
    @(negedge clk); step = 0;
    m_state = {m_state[W-2:0], ^(m_state & TAPS)};
    expq.push_back(model_out(m_state, m_wt, m_en));
    tagq.push_back(tag);
  endtask

  task automatic run_steps(int n, string tag);
    for (int i = 0; i < n; i++) do_step(tag);
    @(negedge clk); @(negedge clk); @(negedge clk);
  endtask

  task automatic load_cfg(logic [W-1:0] seed, logic [2*N-1:0] wt, logic [N-1:0] en, bit step_inside);
    logic [RING-1:0] v;
    v = {en, wt, seed};
    @(negedge clk); cfg_shift = 1;
    for (int i = RING - 1; i >= 0; i--) begin
      cfg_bit = v[i];
      if (step_inside && i == RING / 2) step = 1;
      @(negedge clk);
      step = 0;
      // R9: outputs unchanged mid-load
      if (step_inside && i == RING / 2)
        check("R9 mid-load output", chan_out, model_out(m_state, m_wt, m_en));
    end
    cfg_shift = 0;
    @(negedge clk); @(negedge clk);
    m_state = (seed == '0) ? ZSUB : seed;
    m_wt = wt; m_en = en;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset output", chan_out, '0);
    rst = 0;
    @(negedge clk);
    check("R1 after reset", chan_out, '0);
    run_steps(4, "R1 enables cleared after reset");

    // R2 R5 R6 mixed weights
    load_cfg(32'h1357_9BDF, 16'b11_10_01_00_11_10_01_00, 8'hFF, 0);
    check("R2 applied config", chan_out, model_out(m_state, m_wt, m_en));
    run_steps(60, "R5 R6 mixed weights");

    // R7 partial enables
    load_cfg(32'hDEAD_BEEF, 16'hAAAA, 8'b1010_0101, 0);
    check("R7 partial enable", chan_out, model_out(m_state, m_wt, m_en));
    run_steps(40, "R7 partial enables");

    // R6 all one-eighth
    load_cfg(32'h0F0F_A5A5, 16'hFFFF, 8'hFF, 0);
    run_steps(40, "R6 eighth weight");

    // R3 zero seed
    load_cfg(32'h0, 16'h0000, 8'hFF, 0);
    check("R3 zero seed substitute", chan_out, model_out(ZSUB, m_wt, m_en));
    run_steps(20, "R3 R4 after zero seed");

    // R4 R9 step during load ignored, outputs held
    load_cfg(32'h2468_ACE0, 16'h5555, 8'h3C, 1);
    check("R4 R9 step during load", chan_out, model_out(m_state, m_wt, m_en));
    // R8 hold without step
    repeat (5) @(negedge clk);
    check("R8 hold without step", chan_out, model_out(m_state, m_wt, m_en));
    run_steps(30, "R4 R8 stepping");

    // R7 all disabled
    load_cfg(32'h7777_1111, 16'h0000, 8'h00, 0);
    run_steps(10, "R7 all disabled");
    check("R7 all disabled zero", chan_out, '0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule